// File: doc/BRIEF.md
# Gated Clock Divider with Selectable Field Encoding

This block derives one peripheral clock from a source clock. It can optionally pick that source from one of two inputs: the board reference clock or the first PLL output. It divides the selected source by a ratio taken from a register field and can optionally gate the result with an enable bit. A static parameter fixes how the field is decoded: as a one-based count, as a doubled one-based count, as a power of two, or not at all (pass-through). Two other parameters choose whether the source selector and the enable gate are built.

Software writes the enable bit, the selector bit and the divider field together in one write cycle on the reference clock. A new ratio or a new enable state is adopted only at the boundary between two output periods. A change of source goes through a handshake that parks the old clock low before the new one is released. The ratio currently in force is reported on an output so it can be observed.

Top module: `gated_clk_divider`

## Requirements
- R1: After reset the stored enable, selector and field are all 0. The output is held low and `ratio_out` shows the ratio that field value 0 decodes to: 2 in doubled and power-of-two modes, 1 otherwise.
- R2: In one-based mode a field value n gives a ratio of n+1. The output makes one high pulse per output period, half a source period wide, so n=0 reproduces the source.
- R3: In doubled one-based mode a field value n gives a ratio of 2*(n+1) with a 50% duty cycle.
- R4: In power-of-two mode a field value n gives a ratio of 2^(n+1) with a 50% duty cycle. A field value above the ratio width minus 2 saturates at the largest power of two that fits.
- R5: In pass-through mode the ratio is always 1 and the divider field has no effect on the output.
- R6: With the gate built, enable bit 1 lets the clock run and 0 holds the output low. Without the gate the clock always runs.
- R7: An enable change takes effect only at an output period boundary, so a high phase already in progress completes at full width.
- R8: A new field value takes effect only after the current output period has finished.
- R9: Selector 0 takes the reference clock and selector 1 takes the PLL clock. The two sources are never passed at the same time.
- R10: `ratio_out` equals the number of source cycles in the output period currently running.
- R11: The largest value of a narrow field decodes exactly: 15 in a 4-bit one-based field gives 16, and 7 in a 3-bit power-of-two field gives 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Reference clock; also clocks the register write |
| pll_clk | input | 1 | PLL clock, the second source |
| cfg_we | input | 1 | Write strobe for the three fields below |
| cfg_en | input | 1 | Enable bit (1 runs the output) |
| cfg_sel | input | 1 | Source selector (0 reference, 1 PLL) |
| cfg_div | input | DIV_W | Divider field |
| clk_out | output | 1 | Divided, gated output clock |
| ratio_out | output | ratio_width(MODE, DIV_W) | Division ratio currently in force |

## Verification
The hardest situation to create is a configuration write that lands inside an output period. Such a write must leave the current period or high phase untouched. The bench waits for a rising edge of the output and then issues the write immediately. It measures the distance to the next edge, or the width of the ongoing high phase, against the old setting, and then the following period against the new one. Source switching is driven while the divider is running, with a PLL period that is not a multiple of the reference period, so the handshake edges fall at varying phases.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

  // Decode rule for the divider field
  typedef enum logic [1:0] {
    DIV_NONE   = 2'd0,
    DIV_ONE    = 2'd1,
    DIV_DOUBLE = 2'd2,
    DIV_POW2   = 2'd3
  } div_mode_e;

  // Width needed to hold the largest ratio of a mode
  function automatic int ratio_width(div_mode_e mode, int field_w);
    if (mode == DIV_POW2) begin
      return (((1 << field_w) + 1) > 32) ? 32 : ((1 << field_w) + 1);
    end
    return field_w + 2;
  endfunction

endpackage

// File: rtl/rst_sync.sv
`timescale 1ns/1ps
module rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/clk_src_mux.sv
`timescale 1ns/1ps
module clk_src_mux (
  input  logic ref_rst_n,
  input  logic arst_n,
  input  logic ref_clk,
  input  logic pll_clk,
  input  logic sel,
  output logic src_clk
);
  logic pll_rst_n;
  logic ref_arm_q, ref_on_q, pll_arm_q, pll_on_q;
  logic ref_arm_d, pll_arm_d;

  rst_sync u_pll_rst (.clk(pll_clk), .arst_n(arst_n), .srst_n(pll_rst_n));

  // each side arms only once the other side is parked
  assign ref_arm_d = !sel && !pll_on_q;
  assign pll_arm_d =  sel && !ref_on_q;

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) ref_arm_q <= 1'b0;
    else            ref_arm_q <= ref_arm_d;
  end

  always_ff @(negedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) ref_on_q <= 1'b0;
    else            ref_on_q <= ref_arm_q;
  end

  always_ff @(posedge pll_clk or negedge pll_rst_n) begin
    if (!pll_rst_n) pll_arm_q <= 1'b0;
    else            pll_arm_q <= pll_arm_d;
  end

  always_ff @(negedge pll_clk or negedge pll_rst_n) begin
    if (!pll_rst_n) pll_on_q <= 1'b0;
    else            pll_on_q <= pll_arm_q;
  end

  assign src_clk = (ref_clk & ref_on_q) | (pll_clk & pll_on_q);

  // R9
  mux_exclusive_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !(ref_on_q && pll_on_q));
endmodule

// File: rtl/clk_div_core.sv
`timescale 1ns/1ps
module clk_div_core
  import clkdiv_pkg::*;
#(
  parameter int        DIV_W = 8,
  parameter int        RW    = 10,
  parameter div_mode_e MODE  = DIV_DOUBLE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             clk_o,
  output logic [RW-1:0]    ratio
);
  localparam bit LEVEL = (MODE == DIV_DOUBLE) || (MODE == DIV_POW2);
  localparam logic [RW-1:0] RST_RATIO = LEVEL ? RW'(2) : RW'(1);

  logic [RW-1:0] cnt_q, cnt_d, ratio_q, ratio_d, ratio_req;
  logic          run_q, run_d, wrap;

  // field decode
  always_comb begin
    case (MODE)
      DIV_ONE:    ratio_req = RW'(div) + 1'b1;
      DIV_DOUBLE: ratio_req = (RW'(div) + 1'b1) << 1;
      DIV_POW2: begin
        if (int'(div) > RW - 2) ratio_req = RW'(1) << (RW - 1);
        else                    ratio_req = RW'(2) << div;
      end
      default:    ratio_req = RW'(1);
    endcase
  end

  // settings are adopted only when a period closes
  assign wrap = (cnt_q == ratio_q - 1'b1);

  always_comb begin
    if (wrap) begin
      cnt_d   = '0;
      ratio_d = ratio_req;
      run_d   = run;
    end else begin
      cnt_d   = cnt_q + 1'b1;
      ratio_d = ratio_q;
      run_d   = run_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= RST_RATIO;
      run_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      run_q   <= run_d;
    end
  end

  assign ratio = ratio_q;

  generate
    if (LEVEL) begin : g_level
      logic hi_q, hi_d;
      assign hi_d = run_d && (cnt_d < (ratio_d >> 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_q <= 1'b0;
        else        hi_q <= hi_d;
      end
      assign clk_o = hi_q;
      // R3
      level_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_q) |-> (cnt_q == '0) && run_q);
    end else begin : g_pulse
      logic pass_q, pass_d;
      assign pass_d = run_d && (cnt_d == '0);
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) pass_q <= 1'b0;
        else        pass_q <= pass_d;
      end
      assign clk_o = clk & pass_q;
      // R2
      pulse_align_chk: assert property (@(negedge clk) disable iff (!rst_n)
        pass_q |-> (cnt_q == '0) && run_q);
    end
  endgenerate

  // R10
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_q != '0) && (cnt_q < ratio_q));
  // R8
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> $stable(ratio_q));
  // R7
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> $stable(run_q));
endmodule

// File: rtl/gated_clk_divider.sv
`timescale 1ns/1ps
module gated_clk_divider #(
  parameter int                    DIV_W    = 8,
  parameter clkdiv_pkg::div_mode_e MODE     = clkdiv_pkg::DIV_DOUBLE,
  parameter bit                    HAS_MUX  = 1'b1,
  parameter bit                    HAS_GATE = 1'b1
) (
  input  logic                                          rst_n,
  input  logic                                          ref_clk,
  input  logic                                          pll_clk,
  input  logic                                          cfg_we,
  input  logic                                          cfg_en,
  input  logic                                          cfg_sel,
  input  logic [DIV_W-1:0]                              cfg_div,
  output logic                                          clk_out,
  output logic [clkdiv_pkg::ratio_width(MODE, DIV_W)-1:0] ratio_out
);
  localparam int RW = clkdiv_pkg::ratio_width(MODE, DIV_W);

  logic             ref_rst_n, src_rst_n, src_clk, run;
  logic             en_q, en_d, sel_q, sel_d;
  logic [DIV_W-1:0] div_q, div_d;

  rst_sync u_ref_rst (.clk(ref_clk), .arst_n(rst_n), .srst_n(ref_rst_n));

  // setting register, reference domain
  always_comb begin
    en_d  = en_q;
    sel_d = sel_q;
    div_d = div_q;
    if (cfg_we) begin
      en_d  = cfg_en;
      sel_d = cfg_sel;
      div_d = cfg_div;
    end
  end

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      en_q  <= 1'b0;
      sel_q <= 1'b0;
      div_q <= '0;
    end else begin
      en_q  <= en_d;
      sel_q <= sel_d;
      div_q <= div_d;
    end
  end

  generate
    if (HAS_MUX) begin : g_mux
      clk_src_mux u_mux (
        .ref_rst_n (ref_rst_n),
        .arst_n    (rst_n),
        .ref_clk   (ref_clk),
        .pll_clk   (pll_clk),
        .sel       (sel_q),
        .src_clk   (src_clk)
      );
    end else begin : g_direct
      assign src_clk = ref_clk;
    end
    if (HAS_GATE) begin : g_gate
      assign run = en_q;
    end else begin : g_open
      assign run = 1'b1;
    end
  endgenerate

  rst_sync u_src_rst (.clk(src_clk), .arst_n(rst_n), .srst_n(src_rst_n));

  clk_div_core #(.DIV_W(DIV_W), .RW(RW), .MODE(MODE)) u_core (
    .clk   (src_clk),
    .rst_n (src_rst_n),
    .run   (run),
    .div   (div_q),
    .clk_o (clk_out),
    .ratio (ratio_out)
  );
endmodule

// File: tb/sim_gated_clk_divider.sv
`timescale 1ns/1ps
module sim_gated_clk_divider;
  import clkdiv_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int PLL_PERIOD = 6;

  logic        ref_clk = 1'b0;
  logic        pll_clk = 1'b0;
  logic        rst_n   = 1'b0;
  logic [3:0]  we      = 4'b0;
  logic        drv_en  = 1'b0;
  logic        drv_sel = 1'b0;
  logic [15:0] drv_div = '0;

  logic clk0, clk1, clk2, clk3;
  logic [17:0] rat0;
  logic [5:0]  rat1;
  logic [8:0]  rat2;
  logic [9:0]  rat3;

  always #(CLK_PERIOD/2) ref_clk = ~ref_clk;
  always #(PLL_PERIOD/2) pll_clk = ~pll_clk;

  gated_clk_divider #(.DIV_W(16), .MODE(DIV_DOUBLE), .HAS_MUX(1'b1), .HAS_GATE(1'b1)) u0 (
    .rst_n(rst_n), .ref_clk(ref_clk), .pll_clk(pll_clk), .cfg_we(we[0]), .cfg_en(drv_en),
    .cfg_sel(drv_sel), .cfg_div(drv_div), .clk_out(clk0), .ratio_out(rat0));
  gated_clk_divider #(.DIV_W(4), .MODE(DIV_ONE), .HAS_MUX(1'b0), .HAS_GATE(1'b1)) u1 (
    .rst_n(rst_n), .ref_clk(ref_clk), .pll_clk(pll_clk), .cfg_we(we[1]), .cfg_en(drv_en),
    .cfg_sel(drv_sel), .cfg_div(drv_div[3:0]), .clk_out(clk1), .ratio_out(rat1));
  gated_clk_divider #(.DIV_W(3), .MODE(DIV_POW2), .HAS_MUX(1'b0), .HAS_GATE(1'b1)) u2 (
    .rst_n(rst_n), .ref_clk(ref_clk), .pll_clk(pll_clk), .cfg_we(we[2]), .cfg_en(drv_en),
    .cfg_sel(drv_sel), .cfg_div(drv_div[2:0]), .clk_out(clk2), .ratio_out(rat2));
  gated_clk_divider #(.DIV_W(8), .MODE(DIV_NONE), .HAS_MUX(1'b0), .HAS_GATE(1'b0)) u3 (
    .rst_n(rst_n), .ref_clk(ref_clk), .pll_clk(pll_clk), .cfg_we(we[3]), .cfg_en(drv_en),
    .cfg_sel(drv_sel), .cfg_div(drv_div[7:0]), .clk_out(clk3), .ratio_out(rat3));

  int   watch = 0;
  logic mon_clk;
  int   mon_ratio;
  assign mon_clk   = (watch == 0) ? clk0 : (watch == 1) ? clk1 : (watch == 2) ? clk2 : clk3;
  assign mon_ratio = (watch == 0) ? int'(rat0) : (watch == 1) ? int'(rat1) :
                     (watch == 2) ? int'(rat2) : int'(rat3);

  int n_chk = 0, n_bad = 0, n_push = 0, n_done = 0, rises = 0;
  bit finished = 1'b0;

  typedef struct {
    int    per;
    int    hi;
    int    ratio;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always @(posedge mon_clk) rises++;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int d, input bit en, input bit sel, input int div);
    @(negedge ref_clk);
    drv_en  = en;
    drv_sel = sel;
    drv_div = 16'(div);
    we[d]   = 1'b1;
    @(negedge ref_clk);
    we = '0;
  endtask

  // driver side of the scoreboard
  task automatic expect_clock(input int d, input int per, input int hi, input int ratio, input string tag);
    exp_t e;
    watch   = d;
    e.per   = per;
    e.hi    = hi;
    e.ratio = ratio;
    e.tag   = tag;
    exp_q.push_back(e);
    n_push++;
    wait (n_done == n_push);
  endtask

  task automatic expect_quiet(input int d, input int window, input string tag);
    int r0;
    watch = d;
    @(negedge ref_clk);
    r0 = rises;
    #(window);
    check(rises == r0, {tag, " no rising edge"}, rises - r0, 0);
    check(mon_clk == 1'b0, {tag, " held low"}, mon_clk, 0);
  endtask

  // monitor side of the scoreboard
  initial begin
    forever begin
      exp_t e;
      time t0, t1, t2;
      int  r;
      wait (exp_q.size() != 0);
      e = exp_q[0];
      @(posedge mon_clk);
      @(posedge mon_clk);
      t0 = $time;
      @(negedge mon_clk);
      t1 = $time;
      r  = mon_ratio;
      @(posedge mon_clk);
      t2 = $time;
      check((t2 - t0) == e.per, {e.tag, " period"}, t2 - t0, e.per);
      check((t1 - t0) == e.hi,  {e.tag, " high time"}, t1 - t0, e.hi);
      check(r == e.ratio, {e.tag, " ratio_out R10"}, r, e.ratio);
      void'(exp_q.pop_front());
      n_done++;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    time t0, t1;
    #(CLK_PERIOD * 3 + 3);
    rst_n = 1'b1;
    #(CLK_PERIOD * 10);
    @(negedge ref_clk);

    // R1 reset state
    check(rat0 == 18'd2, "R1 doubled ratio after reset", rat0, 2);
    check(rat1 == 6'd1, "R1 one-based ratio after reset", rat1, 1);
    expect_quiet(0, 200, "R1 u0");
    expect_quiet(1, 100, "R1 u1");

    // R5 R6 pass-through without gate runs from reset
    expect_clock(3, 10, 5, 1, "R5 R6 ungated pass-through");
    wr(3, 0, 0, 8'hFF);
    expect_clock(3, 10, 5, 1, "R5 field ignored R6 enable ignored");

    // R3 R6 doubled one-based
    wr(0, 1, 0, 0);
    expect_clock(0, 20, 10, 2, "R3 R6 n=0");
    wr(0, 1, 0, 4);
    expect_clock(0, 100, 50, 10, "R3 n=4");

    // R8 field change lands mid-period
    wr(0, 1, 0, 1);
    expect_clock(0, 40, 20, 4, "R8 before change");
    @(posedge clk0);
    t0 = $time;
    wr(0, 1, 0, 3);
    @(posedge clk0);
    check(($time - t0) == 40, "R8 running period kept", $time - t0, 40);
    t1 = $time;
    @(posedge clk0);
    check(($time - t1) == 80, "R8 new period", $time - t1, 80);

    // R7 R6 disable during a high phase
    @(posedge clk0);
    t0 = $time;
    wr(0, 0, 0, 3);
    @(negedge clk0);
    check(($time - t0) == 40, "R7 high phase completes", $time - t0, 40);
    expect_quiet(0, 300, "R6 R7 disabled");

    // R9 source switching
    wr(0, 1, 1, 1);
    #300;
    expect_clock(0, 24, 12, 4, "R9 PLL source");
    wr(0, 1, 0, 1);
    #300;
    expect_clock(0, 40, 20, 4, "R9 reference source");

    // R2 R11 one-based
    wr(1, 1, 0, 0);
    expect_clock(1, 10, 5, 1, "R2 n=0 reproduces source");
    wr(1, 1, 0, 2);
    expect_clock(1, 30, 5, 3, "R2 n=2");
    wr(1, 1, 0, 15);
    expect_clock(1, 160, 5, 16, "R2 R11 n=15");

    // R4 R11 power of two
    wr(2, 1, 0, 0);
    expect_clock(2, 20, 10, 2, "R4 n=0");
    wr(2, 1, 0, 3);
    expect_clock(2, 160, 80, 16, "R4 n=3");
    wr(2, 1, 0, 7);
    expect_clock(2, 2560, 1280, 256, "R4 R11 n=7");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule